// File: doc/BRIEF.md
# Six-Mode Programmable Countdown Timer Channel

One 16-bit down-counting timer channel that produces six different output waveforms from a single counter. The channel runs on the system clock. The counter clock arrives as a one-cycle enable `cnt_tick`, already sampled from the falling edge of the external counter clock. A `preset_wr` pulse delivers a new preset value. A rising edge on `gate_in` can start or restart counting, in the modes that use it. The channel presents its current count and its output level.

The control is a five-state machine. The states are `ST_IDLE`, `ST_WAIT`, `ST_RUN`, `ST_PULSE` and `ST_DONE`.

- `ST_IDLE` is entered on reset and on every mode change. A preset load leaves it in one of two ways: to `ST_RUN` for the self-starting modes (0, 2, 3, 4), or to `ST_WAIT` for the gate-started modes (1, 5).
- `ST_WAIT` goes to `ST_RUN` on a gate trigger.
- In `ST_RUN`, the count reaching zero moves the strobe modes to `ST_PULSE`. In modes 0 and 1 it moves to `ST_DONE`.
- `ST_PULSE` moves to `ST_DONE` after one counter clock.
- A gate trigger returns any state except `ST_IDLE` to `ST_RUN`.
- The periodic modes stay in `ST_RUN` and reload themselves.

When several events fall in the same cycle, they are taken in this order: mode change, then a self-starting load, then a gate trigger, then a counter clock.

Top module: `timer_channel`

## Requirements
- R1: After reset, count_val is 0 and timer_out is 0. The channel is in mode 0 and idle, and counter clocks do not change the count.
- R2: Mode 0 (mode_sel=0). A preset load sets count_val to the preset and timer_out low at the next clock. Each counter clock then subtracts one, and with no counter clock the count holds. The counter clock that brings the count to 0 raises timer_out. The output then stays high and the count stays at 0.
- R3: Mode 1 (mode_sel=1). A preset load alone starts nothing. A gate rising edge loads the preset and drives timer_out low, and each counter clock subtracts one. timer_out returns high on the counter clock that reaches 0, so it is low for exactly preset counter clocks. A further gate edge restarts from the preset.
- R4: Mode 2 (mode_sel=2). A load of preset N sets the count to N with timer_out high. timer_out is low only while the count is 1, which lasts one counter clock. The next counter clock reloads N and raises timer_out, giving a period of N counter clocks. A gate rising edge reloads N.
- R5: Mode 3 (mode_sel=3) with an even preset N. The count starts at N and drops by two per counter clock. timer_out is high for N/2 counter clocks, then low for N/2, repeating.
- R6: Mode 3 with an odd preset N. The count starts at N-1. timer_out is high for (N+1)/2 counter clocks and low for (N-1)/2, with every reload using N-1.
- R7: Mode 4 (mode_sel=4). A preset load starts counting with timer_out high. On the counter clock that brings the count to 0, timer_out goes low. On the next counter clock it returns high, and the count then stays at 0.
- R8: Mode 5 (mode_sel=5). A preset load starts nothing and the count does not move. A gate rising edge loads the preset, and the strobe of R7 follows.
- R9: In modes 0 and 4, a gate rising edge changes neither the count nor timer_out.
- R10: A preset of 0 counts 65536 counter clocks. In mode 0, the first counter clock gives 65535 and the 65536th raises timer_out.
- R11: In modes 2 and 3, a load of the value 1 is ignored. The count, the output and the stored preset stay unchanged.
- R12: A change of mode_sel sets timer_out at the next clock: low for mode 0, high for every other mode. The count holds, and counter clocks and gate edges have no effect until the next preset load.
- R13: mode_sel values 6 and 7 behave as modes 2 and 3 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | One-cycle counter-clock enable (sampled falling edge) |
| gate_in | input | 1 | Gate level; its rising edge is the trigger |
| mode_sel | input | 3 | Operating mode 0..7 |
| preset_val | input | W | Preset value to load |
| preset_wr | input | 1 | One-cycle pulse marking a new preset load |
| count_val | output | W | Current count |
| timer_out | output | 1 | Timer output level |

## Verification
The hardest situation to reach from the ports is the terminal event with a zero preset. That event needs 65536 counter clocks. The bench holds `cnt_tick` high for every system clock and checks the count one step after the load and again one step before the output rises. The odd square-wave asymmetry is also hidden: it appears only as an extra step through a count of zero during the high phase. The bench therefore sweeps every preset from 2 to 9 over three full periods and compares each counter clock with the phase formula.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MD_TERM     = 3'd0,
        MD_ONESHOT  = 3'd1,
        MD_RATE     = 3'd2,
        MD_SQUARE   = 3'd3,
        MD_SWSTROBE = 3'd4,
        MD_HWSTROBE = 3'd5
    } tmr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_PULSE,
        ST_DONE
    } tmr_state_e;

endpackage

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_raw,
    output tmr_mode_e  mode_eff,
    output tmr_mode_e  mode_q,
    output logic       mode_chg,
    output logic       init_hi,
    output logic       need_trig,
    output logic       trig_en
);

    // Codes 6 and 7 fold onto the two periodic modes.
    always_comb begin
        if (mode_raw[2] && mode_raw[1])
            mode_eff = tmr_mode_e'({1'b0, mode_raw[1:0]});
        else
            mode_eff = tmr_mode_e'(mode_raw);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MD_TERM;
        else        mode_q <= mode_eff;
    end

    assign mode_chg = (mode_eff != mode_q);

    always_comb begin
        init_hi   = 1'b1;
        need_trig = 1'b0;
        trig_en   = 1'b0;
        unique case (mode_eff)
            MD_TERM:     init_hi = 1'b0;
            MD_ONESHOT:  begin need_trig = 1'b1; trig_en = 1'b1; end
            MD_RATE:     trig_en = 1'b1;
            MD_SQUARE:   trig_en = 1'b1;
            MD_SWSTROBE: ;
            MD_HWSTROBE: begin need_trig = 1'b1; trig_en = 1'b1; end
            default:     ;
        endcase
    end

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    output logic rise
);

    logic din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = en && din && !din_q;

endmodule

// File: rtl/timer_fsm.sv
module timer_fsm
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic         trig,
    input  logic         mode_chg,
    input  tmr_mode_e    mode,
    input  logic         init_hi,
    input  logic         need_trig,
    input  logic [W-1:0] preset_in,
    output logic [W-1:0] count,
    output logic         out,
    output tmr_state_e   state
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TWO  = W'(2);
    localparam logic [W-1:0] ZERO = '0;

    tmr_state_e   n_state;
    logic [W-1:0] preset_q, n_preset, rel_n, n_count;
    logic         n_out, load_ok, periodic;

    assign periodic = (mode == MD_RATE) || (mode == MD_SQUARE);
    assign load_ok  = load && !(periodic && preset_in == ONE);
    assign n_preset = (load_ok && !mode_chg) ? preset_in : preset_q;
    // An odd square-wave preset is trimmed to the even value below it.
    assign rel_n    = (mode == MD_SQUARE && n_preset[0]) ? n_preset - ONE : n_preset;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= n_state;
    end

    always_comb begin
        n_state = state;
        n_count = count;
        n_out   = out;
        if (mode_chg) begin
            n_state = ST_IDLE;
            n_out   = init_hi;
        end else if (load_ok && !need_trig) begin
            n_state = ST_RUN;
            n_count = rel_n;
            n_out   = (mode != MD_TERM);
        end else if (trig && state != ST_IDLE) begin
            n_state = ST_RUN;
            n_count = rel_n;
            n_out   = (mode != MD_ONESHOT);
        end else begin
            if (load_ok && state == ST_IDLE) n_state = ST_WAIT;
            if (tick) begin
                unique case (state)
                    ST_RUN: begin
                        case (mode)
                            MD_RATE: begin
                                if (count == ONE) begin
                                    n_count = rel_n;
                                    n_out   = 1'b1;
                                end else begin
                                    n_count = count - ONE;
                                    if (count == TWO) n_out = 1'b0;
                                end
                            end
                            MD_SQUARE: begin
                                if (count == TWO) begin
                                    if (preset_q[0] && out) begin
                                        n_count = ZERO;
                                    end else begin
                                        n_count = rel_n;
                                        n_out   = !out;
                                    end
                                end else if (count == ZERO && preset_q[0] && out) begin
                                    n_count = rel_n;
                                    n_out   = 1'b0;
                                end else begin
                                    n_count = count - TWO;
                                end
                            end
                            MD_SWSTROBE, MD_HWSTROBE: begin
                                n_count = count - ONE;
                                if (count == ONE) begin
                                    n_out   = 1'b0;
                                    n_state = ST_PULSE;
                                end
                            end
                            default: begin
                                n_count = count - ONE;
                                if (count == ONE) begin
                                    n_out   = 1'b1;
                                    n_state = ST_DONE;
                                end
                            end
                        endcase
                    end
                    ST_PULSE: begin
                        n_out   = 1'b1;
                        n_state = ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= ZERO;
            out      <= 1'b0;
            preset_q <= ZERO;
        end else begin
            count    <= n_count;
            out      <= n_out;
            preset_q <= n_preset;
        end
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick,
    input  logic         gate_in,
    input  logic [2:0]   mode_sel,
    input  logic [W-1:0] preset_val,
    input  logic         preset_wr,
    output logic [W-1:0] count_val,
    output logic         timer_out
);

    tmr_mode_e  mode_eff, cur_mode;
    tmr_state_e cur_state;
    logic       mode_chg, init_hi, need_trig, trig_en, gate_trig;

    tmr_mode_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_raw  (mode_sel),
        .mode_eff  (mode_eff),
        .mode_q    (cur_mode),
        .mode_chg  (mode_chg),
        .init_hi   (init_hi),
        .need_trig (need_trig),
        .trig_en   (trig_en)
    );

    tmr_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gate_in),
        .en    (trig_en),
        .rise  (gate_trig)
    );

    timer_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .load      (preset_wr),
        .trig      (gate_trig),
        .mode_chg  (mode_chg),
        .mode      (mode_eff),
        .init_hi   (init_hi),
        .need_trig (need_trig),
        .preset_in (preset_val),
        .count     (count_val),
        .out       (timer_out),
        .state     (cur_state)
    );

endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_tick,
    input logic         gate_in,
    input logic         preset_wr,
    input logic [W-1:0] preset_val,
    input logic [W-1:0] count_val,
    input logic         timer_out,
    input logic         mode_chg,
    input logic         gate_trig,
    input tmr_mode_e    cur_mode,
    input tmr_state_e   cur_state
);

    // R1: the count moves only on a counter clock, a load or a trigger
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !preset_wr && !gate_trig) |=> $stable(count_val));

    // R2: a counting mode-0 channel steps down by exactly one
    p_term_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !preset_wr && !mode_chg && cur_mode == MD_TERM && cur_state == ST_RUN)
        |=> (count_val == $past(count_val) - W'(1)));

    // R2: a mode-0 load drives the output low and takes the preset
    p_term_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_wr && !mode_chg && cur_mode == MD_TERM)
        |=> (!timer_out && count_val == $past(preset_val)));

    // R4: the rate output is low only at a count of one
    p_rate_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MD_RATE && !timer_out) |-> (count_val == W'(1)));

    // R7: a strobe low lasts no more than one counter clock
    p_strobe_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == MD_SWSTROBE || cur_mode == MD_HWSTROBE) && !timer_out && cnt_tick && !mode_chg)
        |=> timer_out);

    // R9: a gate edge is inert in modes 0 and 4
    p_gate_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_in && !$past(gate_in) && !cnt_tick && !preset_wr && !mode_chg &&
         (cur_mode == MD_TERM || cur_mode == MD_SWSTROBE))
        |=> ($stable(count_val) && $stable(timer_out)));

    // R11: a load of one is refused by the periodic modes
    p_reject_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_wr && preset_val == W'(1) && !cnt_tick && !gate_trig && !mode_chg &&
         (cur_mode == MD_RATE || cur_mode == MD_SQUARE))
        |=> ($stable(count_val) && $stable(timer_out)));

    // R12: a mode change sets the new mode's initial level and keeps the count
    p_mode_init_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (timer_out == (cur_mode != MD_TERM) && $stable(count_val)));

endmodule

bind timer_channel timer_channel_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .gate_in    (gate_in),
    .preset_wr  (preset_wr),
    .preset_val (preset_val),
    .count_val  (count_val),
    .timer_out  (timer_out),
    .mode_chg   (mode_chg),
    .gate_trig  (gate_trig),
    .cur_mode   (cur_mode),
    .cur_state  (cur_state)
);

// File: tb/timer_channel_test.sv
module timer_channel_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b0;
    logic         gate_in = 1'b0;
    logic         preset_wr = 1'b0;
    logic [2:0]   mode_sel = 3'd0;
    logic [W-1:0] preset_val = '0;
    logic [W-1:0] count_val;
    logic         timer_out;

    int n_checks = 0;
    int n_errors = 0;

    timer_channel #(.W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_tick   (cnt_tick),
        .gate_in    (gate_in),
        .mode_sel   (mode_sel),
        .preset_val (preset_val),
        .preset_wr  (preset_wr),
        .count_val  (count_val),
        .timer_out  (timer_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // one system clock: drive at the falling edge, results visible just after the rising edge
    task automatic cyc(input logic t, input logic g, input logic ld);
        @(negedge clk);
        cnt_tick  = t;
        gate_in   = g;
        preset_wr = ld;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
    endtask

    task automatic load(input int v);
        @(negedge clk);
        preset_val = W'(v);
        cyc_inputs_only();
    endtask

    task automatic cyc_inputs_only();
        cnt_tick  = 1'b0;
        gate_in   = 1'b0;
        preset_wr = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input int m);
        @(negedge clk);
        mode_sel  = 3'(m);
        cnt_tick  = 1'b0;
        gate_in   = 1'b0;
        preset_wr = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 190000);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int c0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset count", count_val, 0);
        check("R1 reset out", timer_out, 0);
        ticks(2);
        check("R1 idle count", count_val, 0);

        // R2: mode 0 sweep
        for (int n = 1; n <= 8; n++) begin
            set_mode(1);
            set_mode(0);
            check("R12 mode0 level", timer_out, 0);
            load(n);
            check("R2 load count", count_val, n);
            check("R2 load out", timer_out, 0);
            cyc(1'b0, 1'b0, 1'b0);
            check("R2 hold without tick", count_val, n);
            for (int k = 1; k < n; k++) begin
                ticks(1);
                check("R2 count step", count_val, n - k);
                check("R2 out low", timer_out, 0);
            end
            ticks(1);
            check("R2 terminal count", count_val, 0);
            check("R2 terminal out", timer_out, 1);
            ticks(2);
            check("R2 after count", count_val, 0);
            check("R2 after out", timer_out, 1);
        end

        // R9: gate inert in mode 0
        load(5);
        cyc(1'b0, 1'b1, 1'b0);
        check("R9 mode0 gate count", count_val, 5);
        check("R9 mode0 gate out", timer_out, 0);
        ticks(1);
        check("R9 mode0 then tick", count_val, 4);

        // R10: zero preset gives 65536 steps
        load(0);
        ticks(1);
        check("R10 first step", count_val, 65535);
        check("R10 first out", timer_out, 0);
        ticks(65534);
        check("R10 last count", count_val, 1);
        check("R10 last out", timer_out, 0);
        ticks(1);
        check("R10 terminal count", count_val, 0);
        check("R10 terminal out", timer_out, 1);

        // R3: one-shot sweep
        for (int n = 1; n <= 5; n++) begin
            set_mode(0);
            set_mode(1);
            check("R12 mode1 level", timer_out, 1);
            c0 = count_val;
            load(n);
            ticks(2);
            check("R3 load alone count", count_val, c0);
            check("R3 load alone out", timer_out, 1);
            cyc(1'b0, 1'b1, 1'b0);
            check("R3 trigger count", count_val, n);
            check("R3 trigger out", timer_out, 0);
            ticks(n - 1);
            check("R3 before end count", count_val, 1);
            check("R3 before end out", timer_out, 0);
            ticks(1);
            check("R3 end count", count_val, 0);
            check("R3 end out", timer_out, 1);
        end
        load(4);
        cyc(1'b0, 1'b1, 1'b0);
        ticks(2);
        check("R3 retrig mid count", count_val, 2);
        cyc(1'b0, 1'b1, 1'b0);
        check("R3 retrig count", count_val, 4);
        check("R3 retrig out", timer_out, 0);
        ticks(3);
        check("R3 retrig still low", timer_out, 0);
        ticks(1);
        check("R3 retrig end out", timer_out, 1);

        // R4: rate generator sweep
        for (int n = 2; n <= 9; n++) begin
            set_mode(0);
            set_mode(2);
            check("R12 mode2 level", timer_out, 1);
            load(n);
            check("R4 load count", count_val, n);
            check("R4 load out", timer_out, 1);
            for (int k = 1; k <= 3 * n; k++) begin
                ticks(1);
                check("R4 rate out", timer_out, ((k % n) == n - 1) ? 0 : 1);
                check("R4 rate count", count_val, ((k % n) == 0) ? n : n - (k % n));
            end
        end
        load(6);
        ticks(2);
        cyc(1'b0, 1'b1, 1'b0);
        check("R4 gate reload count", count_val, 6);
        check("R4 gate reload out", timer_out, 1);

        // R5 / R6: square wave sweep
        for (int n = 2; n <= 9; n++) begin
            set_mode(0);
            set_mode(3);
            load(n);
            check((n % 2) ? "R6 odd load count" : "R5 even load count", count_val, n - (n % 2));
            check("R5 load out", timer_out, 1);
            for (int k = 1; k <= 3 * n; k++) begin
                ticks(1);
                check((n % 2) ? "R6 odd square out" : "R5 even square out",
                      timer_out, ((k % n) >= (n + 1) / 2) ? 0 : 1);
            end
        end

        // R7: software strobe sweep
        for (int n = 1; n <= 6; n++) begin
            set_mode(0);
            set_mode(4);
            load(n);
            check("R7 load count", count_val, n);
            check("R7 load out", timer_out, 1);
            ticks(n - 1);
            check("R7 before expiry count", count_val, 1);
            check("R7 before expiry out", timer_out, 1);
            ticks(1);
            check("R7 expiry count", count_val, 0);
            check("R7 expiry out", timer_out, 0);
            ticks(1);
            check("R7 strobe end out", timer_out, 1);
            ticks(1);
            check("R7 settled count", count_val, 0);
            check("R7 settled out", timer_out, 1);
        end
        load(5);
        cyc(1'b0, 1'b1, 1'b0);
        check("R9 mode4 gate count", count_val, 5);
        check("R9 mode4 gate out", timer_out, 1);
        ticks(1);
        check("R9 mode4 then tick", count_val, 4);

        // R8: hardware strobe sweep
        for (int n = 1; n <= 6; n++) begin
            set_mode(0);
            set_mode(5);
            c0 = count_val;
            load(n);
            ticks(2);
            check("R8 load alone count", count_val, c0);
            check("R8 load alone out", timer_out, 1);
            cyc(1'b0, 1'b1, 1'b0);
            check("R8 trigger count", count_val, n);
            check("R8 trigger out", timer_out, 1);
            ticks(n);
            check("R8 expiry count", count_val, 0);
            check("R8 expiry out", timer_out, 0);
            ticks(1);
            check("R8 strobe end out", timer_out, 1);
        end

        // R11: load of one refused in periodic modes
        set_mode(0);
        set_mode(2);
        load(5);
        ticks(2);
        load(1);
        check("R11 rate reject count", count_val, 3);
        check("R11 rate reject out", timer_out, 1);
        ticks(1);
        check("R11 rate keeps running", count_val, 2);
        set_mode(3);
        c0 = count_val;
        load(1);
        ticks(2);
        check("R11 square reject count", count_val, c0);
        load(4);
        check("R11 square accepts 4", count_val, 4);

        // R12: mode change stops counting
        set_mode(0);
        load(5);
        ticks(2);
        check("R12 pre change count", count_val, 3);
        set_mode(2);
        check("R12 change out", timer_out, 1);
        check("R12 change count", count_val, 3);
        ticks(3);
        check("R12 stopped count", count_val, 3);
        cyc(1'b0, 1'b1, 1'b0);
        check("R12 idle gate count", count_val, 3);
        set_mode(0);
        check("R12 back to mode0 out", timer_out, 0);

        // R13: codes 6 and 7 alias the periodic modes
        set_mode(6);
        check("R13 mode6 level", timer_out, 1);
        load(3);
        ticks(1);
        check("R13 mode6 step", count_val, 2);
        ticks(1);
        check("R13 mode6 low", timer_out, 0);
        ticks(1);
        check("R13 mode6 reload", count_val, 3);
        check("R13 mode6 high", timer_out, 1);
        set_mode(7);
        load(4);
        ticks(1);
        check("R13 mode7 step", count_val, 2);
        check("R13 mode7 high", timer_out, 1);
        ticks(1);
        check("R13 mode7 toggle", timer_out, 0);
        check("R13 mode7 reload", count_val, 4);

        finish_run();
    end

endmodule